// File: doc/BRIEF.md
# USB Endpoint Interrupt Generator

This block sits beside a USB serial interface engine and turns its per-endpoint transaction strobes into interrupt requests. There are three endpoints: one control endpoint (endpoint 0) and two non-control endpoints (endpoints 1 and 2). Each endpoint gets one request line. The line pulses for one cycle when any trigger that applies to that endpoint occurs and that endpoint's enable bit is set.

The triggers are:
- valid OUT data stored in the endpoint;
- an OUT data packet with a bad CRC, which counts only while the endpoint is in an ACK-OUT mode;
- a NAK or STALL that the device sent in answer to an IN attempt;
- a NAK or STALL that the device sent in answer to an OUT attempt;
- for the non-control endpoints, a host ACK that closes a successful IN;
- for the control endpoint, entry into the SETUP-accepting mode;
- for the control endpoint, the end of a zero-length status stage.

Firmware writes the three enable bits through an 8-bit configuration port and reads them back through the same port.

Top module: `ep_irq_gen`

## Requirements
- R1: After reset the configuration readback is 0x00 and all three request lines are low.
- R2: A write stores cfg_wdata bits 2:0 as the enables. Bit i is the enable for endpoint i. The readback shows the stored enables on bits 2:0, and bits 7:3 always read 0 whatever is written to them.
- R3: A good-OUT-data strobe on an enabled endpoint raises that endpoint's request in the cycle after the strobe.
- R4: A bad-CRC OUT strobe raises the request only while that endpoint's mode code is 4'h9 or 4'h3, which are the ACK-OUT modes. Under any other mode code it has no effect.
- R5: A strobe reporting a NAK or STALL sent on an IN attempt raises the endpoint's request.
- R6: A strobe reporting a NAK or STALL sent on an OUT attempt raises the endpoint's request.
- R7: An IN-ACK strobe raises the request of endpoint 1 or 2. On endpoint 0 it has no effect.
- R8: When endpoint 0's mode code changes into 4'h1 (SETUP-accepting) from any other code, endpoint 0's request is raised once. Holding the code at 4'h1 raises nothing more. Code 4'h1 on endpoint 1 or 2 raises nothing.
- R9: A zero-length status-stage strobe raises endpoint 0's request.
- R10: A request line never rises while its own enable bit is 0. The other endpoints are not affected by that bit.
- R11: A request is a single-cycle pulse. Several triggers on one endpoint in the same cycle give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write data |
| cfg_rdata | output | 8 | Enable register readback |
| ep_mode | input | 12 | Mode code per endpoint; 4 bits each, endpoint i in bits 4i+3:4i |
| evt_rx_good | input | 3 | Valid OUT data stored, one bit per endpoint |
| evt_rx_bad | input | 3 | OUT data received with bad CRC |
| evt_in_nak | input | 3 | NAK/STALL sent on an IN attempt |
| evt_out_nak | input | 3 | NAK/STALL sent on an OUT attempt |
| evt_in_ack | input | 3 | Host ACK after a successful IN |
| evt_status_zlp | input | 1 | Endpoint 0 zero-length status stage done |
| irq | output | 3 | Interrupt request pulse per endpoint |

## Verification
The bench checks that a bad-CRC strobe is filtered by the mode code. It uses both ACK-OUT codes and a non-ACK-OUT code, so a design that ignores the mode would fire under code 4'h5 or stay silent under 4'h3. It checks that an IN-ACK on endpoint 0 stays silent while endpoints 1 and 2 fire, and it checks partial enable masks, so that an enable bit wired to the wrong endpoint shows up. The SETUP trigger is checked as an edge: a level-sensitive design would keep asserting while the mode is held, and a design without the endpoint-0 restriction would fire on endpoint 1. The reserved configuration bits are written as ones to catch a readback that is not masked.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_SETUP_RX = 4'h1;
  localparam logic [MODE_W-1:0] MODE_ACK_OUT  = 4'h9;
  localparam logic [MODE_W-1:0] MODE_ACK_OUT_STAT = 4'h3;

  function automatic logic is_ack_out(input logic [MODE_W-1:0] mode);
    return (mode == MODE_ACK_OUT) || (mode == MODE_ACK_OUT_STAT);
  endfunction

  function automatic logic is_setup_rx(input logic [MODE_W-1:0] mode);
    return mode == MODE_SETUP_RX;
  endfunction
endpackage

// File: rtl/ep_irq_cfg.sv
module ep_irq_cfg #(
  parameter int NUM_EP = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [NUM_EP-1:0] en_q
);
  localparam int PAD_W = REG_W - NUM_EP;

  logic wdata_unused;
  assign wdata_unused = ^wdata[REG_W-1:NUM_EP];

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata[NUM_EP-1:0];
  end

  assign rdata = {{PAD_W{1'b0}}, en_q};
endmodule

// File: rtl/ep_irq_setup_det.sv
module ep_irq_setup_det
  import ep_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  logic [MODE_W-1:0] mode_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_prev <= '0;
    else        mode_prev <= mode;
  end

  assign hit = is_setup_rx(mode) && !is_setup_rx(mode_prev);
endmodule

// File: rtl/ep_irq_ep.sv
module ep_irq_ep
  import ep_irq_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              rx_good,
  input  logic              rx_bad,
  input  logic              in_nak,
  input  logic              out_nak,
  input  logic              in_ack,
  input  logic              zlp_done,
  input  logic              setup_hit,
  output logic              trig
);
  logic bad_ok, ack_ok, zlp_ok, setup_ok;

  assign bad_ok   = rx_bad & is_ack_out(mode);
  assign ack_ok   = IS_CTRL ? 1'b0 : in_ack;
  assign zlp_ok   = IS_CTRL ? zlp_done : 1'b0;
  assign setup_ok = IS_CTRL ? setup_hit : 1'b0;

  assign trig = rx_good | bad_ok | in_nak | out_nak | ack_ok | zlp_ok | setup_ok;
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int REG_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [REG_W-1:0]              cfg_wdata,
  output logic [REG_W-1:0]              cfg_rdata,
  input  logic [NUM_EP-1:0][MODE_W-1:0] ep_mode,
  input  logic [NUM_EP-1:0]             evt_rx_good,
  input  logic [NUM_EP-1:0]             evt_rx_bad,
  input  logic [NUM_EP-1:0]             evt_in_nak,
  input  logic [NUM_EP-1:0]             evt_out_nak,
  input  logic [NUM_EP-1:0]             evt_in_ack,
  input  logic                          evt_status_zlp,
  output logic [NUM_EP-1:0]             irq
);
  logic [NUM_EP-1:0] en_q;
  logic [NUM_EP-1:0] ep_trig;
  logic              setup_hit;

  ep_irq_cfg #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .en_q  (en_q)
  );

  ep_irq_setup_det u_setup (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (ep_mode[0]),
    .hit   (setup_hit)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_irq_ep #(.IS_CTRL(g == 0)) u_ep (
      .mode      (ep_mode[g]),
      .rx_good   (evt_rx_good[g]),
      .rx_bad    (evt_rx_bad[g]),
      .in_nak    (evt_in_nak[g]),
      .out_nak   (evt_out_nak[g]),
      .in_ack    (evt_in_ack[g]),
      .zlp_done  (evt_status_zlp),
      .setup_hit (setup_hit),
      .trig      (ep_trig[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= '0;
    else        irq <= ep_trig & en_q;
  end
endmodule

// File: rtl/ep_irq_chk.sv
module ep_irq_chk #(
  parameter int NUM_EP = 3,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic [NUM_EP-1:0] en_q,
  input logic [NUM_EP-1:0] evt_rx_good,
  input logic [NUM_EP-1:0] evt_in_nak,
  input logic [NUM_EP-1:0] evt_out_nak,
  input logic              evt_status_zlp,
  input logic [NUM_EP-1:0] irq
);
  // R2
  rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:NUM_EP] == '0);

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata[NUM_EP-1:0] == $past(cfg_wdata[NUM_EP-1:0])));

  // R10
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~$past(en_q)) == '0);

  // R3
  rx_good_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_rx_good) & $past(en_q)) & ~irq) == '0);

  // R5
  in_nak_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_in_nak) & $past(en_q)) & ~irq) == '0);

  // R6
  out_nak_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_out_nak) & $past(en_q)) & ~irq) == '0);

  // R9
  zlp_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_status_zlp && en_q[0]) |=> irq[0]);
endmodule

bind ep_irq_gen ep_irq_chk #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wr         (cfg_wr),
  .cfg_wdata      (cfg_wdata),
  .cfg_rdata      (cfg_rdata),
  .en_q           (en_q),
  .evt_rx_good    (evt_rx_good),
  .evt_in_nak     (evt_in_nak),
  .evt_out_nak    (evt_out_nak),
  .evt_status_zlp (evt_status_zlp),
  .irq            (irq)
);

// File: tb/ep_irq_gen_test.sv
module ep_irq_gen_test;
  localparam int NUM_EP = 3;
  localparam int REG_W  = 8;
  localparam int NV     = 14;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    cfg_wr = 1'b0;
  logic [REG_W-1:0]        cfg_wdata = '0;
  logic [REG_W-1:0]        cfg_rdata;
  logic [NUM_EP-1:0][3:0]  ep_mode = '0;
  logic [NUM_EP-1:0]       evt_rx_good = '0, evt_rx_bad = '0, evt_in_nak = '0;
  logic [NUM_EP-1:0]       evt_out_nak = '0, evt_in_ack = '0;
  logic                    evt_status_zlp = 1'b0;
  logic [NUM_EP-1:0]       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ep_irq_gen #(.NUM_EP(NUM_EP), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ep_mode(ep_mode), .evt_rx_good(evt_rx_good),
    .evt_rx_bad(evt_rx_bad), .evt_in_nak(evt_in_nak), .evt_out_nak(evt_out_nak),
    .evt_in_ack(evt_in_ack), .evt_status_zlp(evt_status_zlp), .irq(irq)
  );

  // Fields: en[25:23] mode[22:19] good[18:16] bad[15:13] innak[12:10]
  //         outnak[9:7] inack[6:4] zlp[3] expected irq[2:0]
  localparam logic [25:0] VEC [NV] = '{
    {3'b111, 4'h0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0, 3'b111}, // R3
    {3'b111, 4'h0, 3'b000, 3'b111, 3'b000, 3'b000, 3'b000, 1'b0, 3'b000}, // R4
    {3'b111, 4'h9, 3'b000, 3'b111, 3'b000, 3'b000, 3'b000, 1'b0, 3'b111}, // R4
    {3'b111, 4'h3, 3'b000, 3'b010, 3'b000, 3'b000, 3'b000, 1'b0, 3'b010}, // R4
    {3'b111, 4'h5, 3'b000, 3'b100, 3'b000, 3'b000, 3'b000, 1'b0, 3'b000}, // R4
    {3'b111, 4'h0, 3'b000, 3'b000, 3'b101, 3'b000, 3'b000, 1'b0, 3'b101}, // R5
    {3'b111, 4'h0, 3'b000, 3'b000, 3'b000, 3'b011, 3'b000, 1'b0, 3'b011}, // R6
    {3'b111, 4'h0, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111, 1'b0, 3'b110}, // R7
    {3'b111, 4'h0, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 1'b1, 3'b001}, // R9
    {3'b101, 4'h0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0, 3'b101}, // R10
    {3'b010, 4'h0, 3'b000, 3'b000, 3'b111, 3'b000, 3'b000, 1'b0, 3'b010}, // R10
    {3'b000, 4'h9, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 1'b1, 3'b000}, // R10
    {3'b111, 4'h0, 3'b001, 3'b000, 3'b001, 3'b001, 3'b000, 1'b1, 3'b001}, // R11
    {3'b110, 4'h0, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 1'b1, 3'b000}  // R9 / R10
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic clear_events();
    evt_rx_good = '0; evt_rx_bad = '0; evt_in_nak = '0;
    evt_out_nak = '0; evt_in_ack = '0; evt_status_zlp = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 readback", cfg_rdata, 8'h00);
    check("R1 irq", {5'b0, irq}, 8'h00);

    // R2: reserved bits masked, enables stored
    write_cfg(8'hFF);
    check("R2 write ff", cfg_rdata, 8'h07);
    write_cfg(8'hA2);
    check("R2 write a2", cfg_rdata, 8'h02);
    write_cfg(8'h00);
    check("R2 write 00", cfg_rdata, 8'h00);

    // Table walk covering R3, R4, R5, R6, R7, R9, R10, R11
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      write_cfg({5'b0, v[25:23]});
      @(negedge clk);
      for (int e = 0; e < NUM_EP; e++) ep_mode[e] = v[22:19];
      evt_rx_good = v[18:16];
      evt_rx_bad  = v[15:13];
      evt_in_nak  = v[12:10];
      evt_out_nak = v[9:7];
      evt_in_ack  = v[6:4];
      evt_status_zlp = v[3];
      @(negedge clk);
      clear_events();
      check($sformatf("table(R3,R4,R5,R6,R7,R9,R10) vec %0d", i), {5'b0, irq}, {5'b0, v[2:0]});
      @(negedge clk);
      // R11: pulse lasts one cycle
      check($sformatf("R11 pulse end vec %0d", i), {5'b0, irq}, 8'h00);
    end

    // R8: SETUP-accepting mode entry on endpoint 0
    ep_mode = '0;
    write_cfg(8'h07);
    @(negedge clk);
    ep_mode[0] = 4'h1;
    @(negedge clk);
    check("R8 entry", {5'b0, irq}, 8'h01);
    @(negedge clk);
    check("R8 held 1", {5'b0, irq}, 8'h00);
    @(negedge clk);
    check("R8 held 2", {5'b0, irq}, 8'h00);
    ep_mode[0] = 4'h9;
    @(negedge clk);
    check("R8 leave", {5'b0, irq}, 8'h00);
    ep_mode[1] = 4'h1;
    ep_mode[2] = 4'h1;
    @(negedge clk);
    check("R8 other eps", {5'b0, irq}, 8'h00);
    @(negedge clk);
    check("R8 other eps held", {5'b0, irq}, 8'h00);
    ep_mode[0] = 4'h1;
    @(negedge clk);
    check("R8 re-entry", {5'b0, irq}, 8'h01);
    // R10: entry with endpoint 0 disabled
    ep_mode[0] = 4'h0;
    write_cfg(8'h06);
    @(negedge clk);
    ep_mode[0] = 4'h1;
    @(negedge clk);
    check("R10 setup masked", {5'b0, irq}, 8'h00);
    @(negedge clk);
    check("R10 setup masked after", {5'b0, irq}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule